// File: doc/BRIEF.md
# Obfuscated Scan Register Segment

This block is a k-stage piece of a scan chain, meant to sit where a chain passes through registers that hold secret values. In functional mode every stage loads its own bit of a parallel functional input through an ordinary capture mux. In scan mode the stages form a serial path. That path is not a plain delay line. Fixed inverters and forward-only XOR taps, chosen by parameters at design time, are placed between the stages. The scan output is a parity of selected stages, optionally inverted.

The network is arranged so that every scanned-in bit comes back out k cycles later. On the way it is combined by XOR with a constant and with a fixed linear function of the bits shifted in after it. Test software that knows the tap placement can still load any target state in k shifts, starting from any state. The same software can recover the previous state from the bits it shifted in and the bits it observed, while both streams run in the same k cycles. Someone who does not know the placement cannot read out the state directly.

A lock flop is set by reset. While the lock is set, any shift request is turned into a functional capture and the scan output is held low. As a result, the known all-zero reset state can never be shifted out to reveal where the inverters are.

Top module: `obf_scan_segment`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0 and sets the lock. The lock holds the scan output at 0.
- R2: While the lock is set, the scan output is 0. A clock edge captures the functional input even when scan enable is high.
- R3: The lock clears after the first clock edge that follows reset. The next edge with scan enable high shifts, so stage 1 (state bit 0) takes the scan input.
- R4: With scan enable low, every stage loads its functional input bit on the next edge (state bit i-1 is stage i).
- R5: In the default configuration, after three consecutive shifts the scan output equals the scan input applied three cycles earlier, whatever the starting state. The characteristic coefficient is all zeros.
- R6: In a configuration with stages chained plainly, the output taken as stage 3 XOR stage 1, inverted, the serial law is z(t+3) = NOT x(t) XOR x(t+2).
- R7: In the default configuration, shifting in the sequence (d3 XOR d2, d2, d1) leaves stages 1..3 at (d1, d2, d3), whatever the starting state.
- R8: In the default configuration, let z0, z1, z2 be the scan outputs seen before each of three shifts. The starting stages are then stage1 = z2, stage2 = z1, stage3 = z0 XOR z1.
- R9: Loading a new state and unloading the old one happen in the same k shift cycles. No extra cycles are needed.
- R10: In a shift cycle, stage 1 takes the scan input XOR its inverter setting, and the lock stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 selects the serial shift path, 0 selects functional capture |
| scan_in | input | 1 | Serial scan data in |
| func_in | input | K | Functional capture data, bit i-1 feeds stage i |
| scan_out | output | 1 | Serial scan data out, 0 while the lock is set |
| state_out | output | K | Stage contents, bit i-1 is stage i |

## Verification
The assertions watch the rules that hold from one cycle to the next: a quiet output while locked, a forced capture while locked, the lock clearing after one edge, capture whenever scan enable is low, and how the first stage loads in a shift cycle. The multi-cycle serial laws cannot be seen within a single cycle. These are the delay-k identity with its characteristic coefficient, the justification sequence that reaches a chosen target state, and recovery of the previous state from the observed output bits. Only the bench scenarios show them, using a history-based reference model. The bench runs random streams from random starting states and overlaps load with unload.

// File: rtl/obf_scan_pkg.sv
package obf_scan_pkg;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_SHIFT   = 1'b1
    } seg_mode_e;

endpackage

// File: rtl/obf_shift_net.sv
module obf_shift_net #(
    parameter int unsigned       K         = 3,
    parameter logic [K*K-1:0]    STAGE_TAP = '0,
    parameter logic [K-1:0]      IN_INV    = '0,
    parameter logic [K-1:0]      OUT_TAP   = '0,
    parameter logic              OUT_INV   = 1'b0
) (
    input  logic [K-1:0] cur_y,
    input  logic         ser_in,
    output logic [K-1:0] shift_y,
    output logic         ser_raw
);

    // Next value of each stage along the scan path: predecessor, inverter,
    // and forward taps from strictly earlier stages only.
    always_comb begin
        for (int i = 0; i < int'(K); i++) begin
            logic acc;
            acc = (i == 0) ? ser_in : cur_y[(i == 0) ? 0 : i-1];
            acc = acc ^ IN_INV[i];
            for (int j = 0; j < int'(K); j++) begin
                if (j + 1 < i) begin
                    acc = acc ^ (STAGE_TAP[i*int'(K) + j] & cur_y[j]);
                end
            end
            shift_y[i] = acc;
        end
    end

    // Serial output: last stage, forward taps from earlier stages, inverter.
    always_comb begin
        logic acc_o;
        acc_o = cur_y[K-1] ^ OUT_INV;
        for (int j = 0; j + 1 < int'(K); j++) begin
            acc_o = acc_o ^ (OUT_TAP[j] & cur_y[j]);
        end
        ser_raw = acc_o;
    end

endmodule

// File: rtl/obf_capture_mux.sv
module obf_capture_mux
    import obf_scan_pkg::*;
#(
    parameter int unsigned K = 3
) (
    input  seg_mode_e    mode,
    input  logic [K-1:0] func_y,
    input  logic [K-1:0] shift_y,
    output logic [K-1:0] next_y
);

    for (genvar g = 0; g < int'(K); g++) begin : g_cell
        assign next_y[g] = (mode == MODE_SHIFT) ? shift_y[g] : func_y[g];
    end

endmodule

// File: rtl/obf_scan_guard.sv
module obf_scan_guard
    import obf_scan_pkg::*;
(
    input  logic      lock_q,
    input  logic      scan_req,
    input  logic      ser_raw,
    output seg_mode_e mode,
    output logic      lock_d,
    output logic      ser_out
);

    always_comb begin
        mode    = (scan_req && !lock_q) ? MODE_SHIFT : MODE_CAPTURE;
        // A locked cycle is always a capture cycle, so the lock drops after it.
        lock_d  = lock_q && (mode == MODE_SHIFT);
        ser_out = lock_q ? 1'b0 : ser_raw;
    end

endmodule

// File: rtl/obf_scan_segment.sv
module obf_scan_segment
    import obf_scan_pkg::*;
#(
    parameter int unsigned       K         = 3,
    parameter logic [K*K-1:0]    STAGE_TAP = (K*K)'(64),
    parameter logic [K-1:0]      IN_INV    = '0,
    parameter logic [K-1:0]      OUT_TAP   = K'(2),
    parameter logic              OUT_INV   = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [K-1:0] func_in,
    output logic         scan_out,
    output logic [K-1:0] state_out
);

    typedef struct packed {
        logic [K-1:0] y;
        logic         locked;
    } seg_state_t;

    seg_state_t   cur_q;
    seg_state_t   nxt_d;
    logic [K-1:0] shift_y;
    logic [K-1:0] next_y;
    logic         ser_raw;
    logic         lock_d;
    logic         lock_q;
    seg_mode_e    mode;

    assign lock_q = cur_q.locked;

    obf_shift_net #(
        .K(K), .STAGE_TAP(STAGE_TAP), .IN_INV(IN_INV),
        .OUT_TAP(OUT_TAP), .OUT_INV(OUT_INV)
    ) i_net (
        .cur_y   (cur_q.y),
        .ser_in  (scan_in),
        .shift_y (shift_y),
        .ser_raw (ser_raw)
    );

    obf_scan_guard i_guard (
        .lock_q   (lock_q),
        .scan_req (scan_en),
        .ser_raw  (ser_raw),
        .mode     (mode),
        .lock_d   (lock_d),
        .ser_out  (scan_out)
    );

    obf_capture_mux #(.K(K)) i_mux (
        .mode    (mode),
        .func_y  (func_in),
        .shift_y (shift_y),
        .next_y  (next_y)
    );

    always_comb begin
        nxt_d.y      = next_y;
        nxt_d.locked = lock_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.y      <= '0;
            cur_q.locked <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_out = cur_q.y;

endmodule

// File: rtl/obf_scan_segment_chk.sv
module obf_scan_segment_chk #(
    parameter int unsigned  K      = 3,
    parameter logic [K-1:0] IN_INV = '0
) (
    input logic         clk,
    input logic         rst,
    input logic         scan_en,
    input logic         scan_in,
    input logic [K-1:0] func_in,
    input logic [K-1:0] state_out,
    input logic         scan_out,
    input logic         locked
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state_out == '0 && scan_out == 1'b0));

    p_locked_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        locked |-> scan_out == 1'b0);

    p_locked_capture_r2: assert property (@(posedge clk) disable iff (rst)
        locked |=> state_out == $past(func_in));

    p_lock_once_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> !locked);

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> state_out == $past(func_in));

    p_shift_head_r10: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !locked) |=> (state_out[0] == ($past(scan_in) ^ IN_INV[0]) && !locked));

endmodule

bind obf_scan_segment obf_scan_segment_chk #(.K(K), .IN_INV(IN_INV)) i_obf_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .func_in   (func_in),
    .state_out (state_out),
    .scan_out  (scan_out),
    .locked    (lock_q)
);

// File: tb/test_obf_scan_segment.sv
`timescale 1ns/1ps
module test_obf_scan_segment;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_en = 1'b0;
    logic       scan_in = 1'b0;
    logic [2:0] func_in = '0;
    logic       zd, zq;
    logic [2:0] yd, yq;
    int         errors = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    obf_scan_segment i_obf_scan_segment (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_in(func_in), .scan_out(zd), .state_out(yd)
    );

    // Plain chain, output = stage3 ^ stage1, inverted.
    obf_scan_segment #(
        .K(3), .STAGE_TAP(9'd0), .IN_INV(3'b000),
        .OUT_TAP(3'b001), .OUT_INV(1'b1)
    ) i_obf_scan_segment_quasi (
        .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
        .func_in(func_in), .scan_out(zq), .state_out(yq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Inputs driven at the falling edge, one rising edge, back at a falling edge.
    task automatic step(input logic se, input logic si, input logic [2:0] fi);
        scan_en = se; scan_in = si; func_in = fi;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, 1'b0, 3'b111);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit xs[$];
        @(negedge clk);
        do_reset();
        // R1: reset state on both variants
        chk("R1 state", {5'd0, yd}, 8'd0);
        chk("R1 quasi state", {5'd0, yq}, 8'd0);
        chk("R1 scan_out", {7'd0, zd}, 8'd0);
        chk("R1 quasi scan_out", {7'd0, zq}, 8'd0);

        // R2: locked, scan request is turned into a capture
        chk("R2 quiet", {7'd0, zq}, 8'd0);
        step(1'b1, 1'b1, 3'b010);
        chk("R2 forced capture", {5'd0, yd}, 8'h02);
        chk("R2 forced capture quasi", {5'd0, yq}, 8'h02);

        // R3: lock gone, shifting now works
        step(1'b1, 1'b1, 3'b000);
        chk("R3 shift after unlock", {7'd0, yd[0]}, 8'd1);
        chk("R3 shift after unlock quasi", {7'd0, yq[0]}, 8'd1);

        // R4: functional capture, several patterns
        for (int p = 0; p < 6; p++) begin
            logic [2:0] v;
            v = 3'($urandom);
            step(1'b0, 1'($urandom), v);
            chk("R4 capture", {5'd0, yd}, {5'd0, v});
            chk("R4 capture quasi", {5'd0, yq}, {5'd0, v});
        end

        // R5 and R6: random serial stream from a random start
        step(1'b0, 1'b0, 3'($urandom));
        for (int n = 0; n < 60; n++) begin
            bit x;
            x = 1'($urandom);
            if (n >= 3) begin
                chk("R5 delay law", {7'd0, zd}, {7'd0, xs[n-3]});
                chk("R6 quasi law", {7'd0, zq}, {7'd0, xs[n-3] ^ 1'b1 ^ xs[n-1]});
            end
            xs.push_back(x);
            step(1'b1, x, 3'($urandom));
        end

        // R7, R8, R9: overlapped load and unload from random starts
        for (int r = 0; r < 8; r++) begin
            logic [2:0] init, tgt;
            logic       z0, z1, z2;
            init = 3'($urandom);
            tgt  = 3'($urandom);
            step(1'b0, 1'b0, init);
            z0 = zd; step(1'b1, tgt[2] ^ tgt[1], 3'($urandom));
            z1 = zd; step(1'b1, tgt[1], 3'($urandom));
            z2 = zd; step(1'b1, tgt[0], 3'($urandom));
            chk("R7 justify", {5'd0, yd}, {5'd0, tgt});
            chk("R8 recover", {5'd0, z0 ^ z1, z1, z2}, {5'd0, init});
            chk("R9 overlap", {5'd0, yd, z2}, {5'd0, tgt, init[0]});
        end

        // R10: single shift moves scan_in into stage 1
        step(1'b1, 1'b0, 3'b000);
        chk("R10 head", {7'd0, yd[0]}, 8'd0);
        step(1'b1, 1'b1, 3'b000);
        chk("R10 head", {7'd0, yd[0]}, 8'd1);

        // R1/R2 again mid-run: reset, then scan is blocked for one edge
        do_reset();
        chk("R1 mid-run reset", {5'd0, yd}, 8'd0);
        chk("R2 quiet after reset", {6'd0, zd, zq}, 8'd0);
        step(1'b1, 1'b0, 3'b101);
        chk("R2 forced capture again", {5'd0, yd}, 8'h05);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule